// File: doc/BRIEF.md
# Multiplexed Host Bus Port

This block is the host side of a switching device. It has an 8-bit multiplexed address/data bus that works with either of the two common multiplexed microcontroller bus timings. A configuration input selects one of them. The first is the "data strobe plus read/write level" style. The second is the "separate read and write strobes" style. An address phase loads the target address from the shared lines. A data phase then reads or writes a small set of local registers, or goes out as a request to the switch memories. The memories are owned by an arbiter outside this block.

Register accesses are answered at once. A memory access is passed to the arbiter as a valid/ready request. Its acknowledge waits for the first internal port-clock tick after the grant. If no tick arrives, the acknowledge never asserts. At the end of every acknowledged cycle the acknowledge line drives high for one clock and then floats.

An interrupt output reports alarm events that are not masked. The host reads the alarm status, which clears it and disarms the interrupt. The host then rewrites the mask, which arms the interrupt again.

Top module: `mux_host_port`

## Requirements
- R1: The address is taken from `ad_in` on the clock edge where `ale` is seen low after being high (falling edge of the address strobe). Address bit 7 = 1 selects the memory window. Bit 7 = 0 selects a register.
- R2: While `cs_n` is high, no strobe level starts a transfer. No acknowledge is driven, AD is not driven, no memory request is raised and no register is written.
- R3: With `mode_moto` = 1, a transfer is active while `cs_n` = 0 and `ds_rd` = 1. `rw_wr` = 1 makes it a read and `rw_wr` = 0 makes it a write.
- R4: With `mode_moto` = 0, `ds_rd` low with `cs_n` low is a read, and `rw_wr` low with `cs_n` low is a write.
- R5: `ad_oe` is high only while a read transfer is active and `cs_n` is low. It drops in the same cycle the read ends.
- R6: A register access drives `dta_n` low with `dta_oe` high in the cycle after the transfer starts. Read data is on `ad_out` by then.
- R7: A memory-window access raises `mem_req_valid` in the cycle after the start. `mem_req_addr` holds the address low 7 bits. `mem_req_we` is 1 for a write, and `mem_req_wdata` holds the host data. The request stays valid and stable until `mem_req_ready` is seen.
- R8: After the grant, the acknowledge asserts in the cycle after the first `port_tick`. It stays off while no tick arrives. Read data returned with the grant appears on `ad_out`.
- R9: When the transfer ends, `dta_n` is driven high with `dta_oe` high for one cycle, and then `dta_oe` drops.
- R10: Register 0x00 holds alarm status. Each `alarm_in` bit sets its status bit, and the bit stays set. A host read returns the status and clears it. Register 0x01 is the read/write alarm mask. Other register addresses read 0 and ignore writes.
- R11: `irq` is high when the interrupt is armed and some status bit has its mask bit set. A status read disarms it. A mask write arms it again. After reset it is armed and the mask is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low reset |
| mode_moto | input | 1 | 1 = data-strobe with R/W level, 0 = separate read/write strobes |
| cs_n | input | 1 | Chip select, active low |
| ale | input | 1 | Address strobe / latch enable |
| ds_rd | input | 1 | Data strobe (high) or read strobe (low) |
| rw_wr | input | 1 | Read/write level or write strobe (low) |
| ad_in | input | 8 | Multiplexed bus, input side |
| ad_out | output | 8 | Multiplexed bus, read data |
| ad_oe | output | 1 | Drive enable for the bus |
| dta_n | output | 1 | Acknowledge level, active low |
| dta_oe | output | 1 | Drive enable for the acknowledge |
| irq | output | 1 | Interrupt request, active high |
| alarm_in | input | 8 | Alarm event pulses |
| port_tick | input | 1 | Internal port clock edge marker |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request grant |
| mem_req_we | output | 1 | Memory request is a write |
| mem_req_addr | output | 7 | Memory request address |
| mem_req_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, valid with the grant |

## Verification
Some rules are checked by assertions on every cycle:
- the address is loaded on the falling latch strobe;
- the bus drive happens only under chip select;
- a memory request holds valid and stable until ready;
- no request starts without chip select;
- the acknowledge floats only after driving high;
- the interrupt never asserts without an unmasked status bit.

Other behaviour can only be shown by the bench's scenarios:
- acknowledge timing relative to the grant and the port tick;
- that writes without chip select have no effect;
- read-back values in both bus modes;
- the clear-on-read and re-arm sequence, swept over many mask and alarm patterns.

Back-pressure applies only on the memory request: while ready is low, the request is held.

// File: rtl/hbp_pkg.sv
package hbp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_WAIT_TICK,
    ST_ACK,
    ST_RELEASE
  } ack_state_e;
endpackage

// File: rtl/hbp_strobe_decode.sv
module hbp_strobe_decode (
  input  logic mode_moto,
  input  logic cs_n,
  input  logic ds_rd,
  input  logic rw_wr,
  output logic act,
  output logic act_read
);
  logic rd_lvl, wr_lvl;

  always_comb begin
    if (mode_moto) begin
      rd_lvl = !cs_n && ds_rd && rw_wr;
      wr_lvl = !cs_n && ds_rd && !rw_wr;
    end else begin
      rd_lvl = !cs_n && !ds_rd;
      wr_lvl = !cs_n && !rw_wr && ds_rd;
    end
    act      = rd_lvl || wr_lvl;
    act_read = rd_lvl;
  end
endmodule

// File: rtl/hbp_addr_latch.sv
module hbp_addr_latch #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ale,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] addr_q
);
  logic ale_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ale_q  <= 1'b0;
      addr_q <= '0;
    end else begin
      ale_q <= ale;
      if (ale_q && !ale) addr_q <= ad_in;
    end
  end
endmodule

// File: rtl/hbp_alarm_irq.sv
module hbp_alarm_irq #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] alarm_in,
  input  logic          status_rd,
  input  logic          mask_wr,
  input  logic [AW-1:0] mask_wdata,
  output logic [AW-1:0] status,
  output logic [AW-1:0] mask,
  output logic          armed,
  output logic          irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status <= '0;
      mask   <= '0;
      armed  <= 1'b1;
    end else begin
      status <= status_rd ? alarm_in : (status | alarm_in);
      if (mask_wr) mask <= mask_wdata;
      if (mask_wr)        armed <= 1'b1;
      else if (status_rd) armed <= 1'b0;
    end
  end

  assign irq = armed && ((status & mask) != '0);
endmodule

// File: rtl/hbp_ack_fsm.sv
module hbp_ack_fsm
  import hbp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       is_mem,
  input  logic       act,
  input  logic       mem_ready,
  input  logic       port_tick,
  output ack_state_e state,
  output logic       mem_valid,
  output logic       dta_n,
  output logic       dta_oe
);
  ack_state_e nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE:      if (start) nxt = is_mem ? ST_REQ : ST_ACK;
      ST_REQ:       if (mem_ready) nxt = ST_WAIT_TICK;
      ST_WAIT_TICK: if (port_tick) nxt = ST_ACK;
      ST_ACK:       if (!act) nxt = ST_RELEASE;
      ST_RELEASE:   nxt = ST_IDLE;
      default:      nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  assign mem_valid = (state == ST_REQ);
  assign dta_oe    = (state == ST_ACK) || (state == ST_RELEASE);
  assign dta_n     = (state != ST_ACK);
endmodule

// File: rtl/mux_host_port.sv
module mux_host_port
  import hbp_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_moto,
  input  logic          cs_n,
  input  logic          ale,
  input  logic          ds_rd,
  input  logic          rw_wr,
  input  logic [DW-1:0] ad_in,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  output logic          dta_n,
  output logic          dta_oe,
  output logic          irq,
  input  logic [DW-1:0] alarm_in,
  input  logic          port_tick,
  output logic          mem_req_valid,
  input  logic          mem_req_ready,
  output logic          mem_req_we,
  output logic [DW-2:0] mem_req_addr,
  output logic [DW-1:0] mem_req_wdata,
  input  logic [DW-1:0] mem_rdata
);
  localparam int MAW = DW - 1;
  localparam logic [MAW-1:0] REG_STATUS = MAW'(0);
  localparam logic [MAW-1:0] REG_MASK   = MAW'(1);

  logic          act, act_read, act_q, start, is_mem, grant;
  logic [DW-1:0] addr_q, status, mask, rd_data;
  logic          armed;
  ack_state_e    state;

  hbp_strobe_decode u_dec (
    .mode_moto (mode_moto),
    .cs_n      (cs_n),
    .ds_rd     (ds_rd),
    .rw_wr     (rw_wr),
    .act       (act),
    .act_read  (act_read)
  );

  hbp_addr_latch #(.DW(DW)) u_alat (
    .clk    (clk),
    .rst_n  (rst_n),
    .ale    (ale),
    .ad_in  (ad_in),
    .addr_q (addr_q)
  );

  assign is_mem = addr_q[DW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) act_q <= 1'b0;
    else        act_q <= act;
  end

  assign start = act && !act_q && (state == ST_IDLE);

  logic status_rd, mask_wr;
  assign status_rd = start && !is_mem && act_read  && (addr_q[MAW-1:0] == REG_STATUS);
  assign mask_wr   = start && !is_mem && !act_read && (addr_q[MAW-1:0] == REG_MASK);

  hbp_alarm_irq #(.AW(DW)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .alarm_in   (alarm_in),
    .status_rd  (status_rd),
    .mask_wr    (mask_wr),
    .mask_wdata (ad_in),
    .status     (status),
    .mask       (mask),
    .armed      (armed),
    .irq        (irq)
  );

  hbp_ack_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .is_mem    (is_mem),
    .act       (act),
    .mem_ready (mem_req_ready),
    .port_tick (port_tick),
    .state     (state),
    .mem_valid (mem_req_valid),
    .dta_n     (dta_n),
    .dta_oe    (dta_oe)
  );

  assign grant = mem_req_valid && mem_req_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_req_we    <= 1'b0;
      mem_req_addr  <= '0;
      mem_req_wdata <= '0;
      rd_data       <= '0;
    end else begin
      if (start && is_mem) begin
        mem_req_we    <= !act_read;
        mem_req_addr  <= addr_q[MAW-1:0];
        mem_req_wdata <= ad_in;
      end
      if (start && !is_mem && act_read) begin
        if (addr_q[MAW-1:0] == REG_STATUS)    rd_data <= status;
        else if (addr_q[MAW-1:0] == REG_MASK) rd_data <= mask;
        else                                  rd_data <= '0;
      end else if (grant && !mem_req_we) begin
        rd_data <= mem_rdata;
      end
    end
  end

  assign ad_oe  = act_read;
  assign ad_out = rd_data;
endmodule

// File: rtl/hbp_host_port_chk.sv
module hbp_host_port_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs_n,
  input logic          ale,
  input logic [DW-1:0] ad_in,
  input logic [DW-1:0] addr_q,
  input logic          ad_oe,
  input logic          dta_n,
  input logic          dta_oe,
  input logic          irq,
  input logic [DW-1:0] status,
  input logic [DW-1:0] mask,
  input logic          mem_req_valid,
  input logic          mem_req_ready,
  input logic          mem_req_we,
  input logic [DW-2:0] mem_req_addr,
  input logic [DW-1:0] mem_req_wdata
);
  // R1
  addr_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ale) |=> addr_q == $past(ad_in));

  // R5
  ad_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ad_oe |-> !cs_n);

  // R7
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_we) && $stable(mem_req_wdata));

  // R2
  req_needs_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req_valid) |-> $past(!cs_n));

  // R9
  dta_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dta_oe) |-> $past(dta_n));

  // R11
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (status & mask) != '0);
endmodule

bind mux_host_port hbp_host_port_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cs_n          (cs_n),
  .ale           (ale),
  .ad_in         (ad_in),
  .addr_q        (addr_q),
  .ad_oe         (ad_oe),
  .dta_n         (dta_n),
  .dta_oe        (dta_oe),
  .irq           (irq),
  .status        (status),
  .mask          (mask),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_we    (mem_req_we),
  .mem_req_addr  (mem_req_addr),
  .mem_req_wdata (mem_req_wdata)
);

// File: tb/mux_host_port_bench.sv
module mux_host_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       mode_moto = 1'b0;
  logic       cs_n = 1'b1, ale = 1'b0, ds_rd = 1'b1, rw_wr = 1'b1;
  logic [7:0] ad_in = '0, ad_out, alarm_in = '0, mem_rdata = '0, mem_req_wdata;
  logic       ad_oe, dta_n, dta_oe, irq, port_tick = 1'b0;
  logic       mem_req_valid, mem_req_ready = 1'b0, mem_req_we;
  logic [6:0] mem_req_addr;
  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mux_host_port u_mux_host_port (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .cs_n(cs_n), .ale(ale),
    .ds_rd(ds_rd), .rw_wr(rw_wr), .ad_in(ad_in), .ad_out(ad_out), .ad_oe(ad_oe),
    .dta_n(dta_n), .dta_oe(dta_oe), .irq(irq), .alarm_in(alarm_in),
    .port_tick(port_tick), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_we(mem_req_we),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rdata(mem_rdata)
  );

  task automatic check(string req, int actual, int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, actual, expected);
    end
  endtask

  task automatic idle_levels();
    cs_n = 1'b1; rw_wr = 1'b1; ds_rd = mode_moto ? 1'b0 : 1'b1;
  endtask

  task automatic set_addr(logic [7:0] a);
    @(negedge clk); ad_in = a; ale = 1'b1;
    @(negedge clk); ale = 1'b0;
    @(negedge clk);
  endtask

  task automatic strobe_on(bit rd, logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; ad_in = d;
    if (mode_moto) begin rw_wr = rd; ds_rd = 1'b1; end
    else if (rd) ds_rd = 1'b0;
    else rw_wr = 1'b0;
  endtask

  task automatic strobe_off_release();
    @(negedge clk); idle_levels(); #1;
    check("R5 ad_oe after strobe end", ad_oe, 0);
    @(negedge clk);
    check("R9 dta driven high", {dta_oe, dta_n}, 2'b11);
    @(negedge clk);
    check("R9 dta floats", dta_oe, 0);
  endtask

  task automatic reg_access(bit rd, logic [7:0] a, logic [7:0] d, output logic [7:0] q);
    set_addr(a);
    strobe_on(rd, d);
    @(negedge clk);
    check("R6 register ack", {dta_oe, dta_n}, 2'b10);
    check(mode_moto ? "R3 ad_oe level" : "R4 ad_oe level", ad_oe, rd);
    q = ad_out;
    strobe_off_release();
  endtask

  task automatic mem_access(bit rd, logic [6:0] a, logic [7:0] d, logic [7:0] rdv);
    set_addr({1'b1, a});
    strobe_on(rd, d);
    @(negedge clk);
    check("R7 req valid", mem_req_valid, 1);
    check("R7 req addr", mem_req_addr, a);
    check("R7 req we", mem_req_we, !rd);
    if (!rd) check("R7 req wdata", mem_req_wdata, d);
    @(negedge clk);
    check("R7 req held", {mem_req_valid, dta_oe}, 2'b10);
    mem_rdata = rdv; mem_req_ready = 1'b1;
    @(negedge clk); mem_req_ready = 1'b0;
    check("R8 no ack before tick", {mem_req_valid, dta_oe}, 2'b00);
    @(negedge clk);
    check("R8 no ack without tick", dta_oe, 0);
    port_tick = 1'b1;
    @(negedge clk); port_tick = 1'b0;
    check("R8 ack after tick", {dta_oe, dta_n}, 2'b10);
    if (rd) check(mode_moto ? "R3 mem read data" : "R4 mem read data", {ad_oe, ad_out}, {1'b1, rdv});
    strobe_off_release();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] q;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R9 reset dta_oe", dta_oe, 0);
    check("R5 reset ad_oe", ad_oe, 0);
    check("R11 reset irq", irq, 0);
    check("R7 reset req", mem_req_valid, 0);

    for (int mo = 0; mo < 2; mo++) begin
      mode_moto = mo[0]; idle_levels();
      reg_access(1'b0, 8'h01, 8'hA5 ^ 8'(mo), q);
      reg_access(1'b1, 8'h01, 8'h00, q);
      check(mo ? "R3 mask readback" : "R4 mask readback", q, 8'hA5 ^ 8'(mo));
      reg_access(1'b0, 8'h05, 8'h77, q);
      reg_access(1'b1, 8'h05, 8'h00, q);
      check("R10 unused reg reads 0", q, 0);
      for (int a = 3; a < 128; a += 11) begin
        mem_access(1'b0, 7'(a), 8'(a * 7 + mo), 8'h00);
        mem_access(1'b1, 7'(a), 8'h00, 8'(a * 13 + 1));
      end
    end

    // R2: strobes with chip select high do nothing
    for (int mo = 0; mo < 2; mo++) begin
      mode_moto = mo[0]; idle_levels();
      reg_access(1'b0, 8'h01, 8'h5A, q);
      set_addr(8'h01);
      @(negedge clk); ad_in = 8'h3C;
      if (mode_moto) begin ds_rd = 1'b1; rw_wr = 1'b0; end else rw_wr = 1'b0;
      repeat (3) begin
        @(negedge clk);
        check("R2 no ack without cs", {dta_oe, ad_oe}, 2'b00);
      end
      idle_levels();
      reg_access(1'b1, 8'h01, 8'h00, q);
      check("R2 mask unchanged", q, 8'h5A);
      set_addr(8'h85);
      @(negedge clk); ds_rd = mode_moto ? 1'b1 : 1'b0;
      repeat (3) begin
        @(negedge clk);
        check("R2 no mem req without cs", {mem_req_valid, ad_oe}, 2'b00);
      end
      idle_levels();
    end

    // R10: sticky accumulation then clear on read
    mode_moto = 1'b0; idle_levels();
    reg_access(1'b1, 8'h00, 8'h00, q);
    @(negedge clk); alarm_in = 8'h11;
    @(negedge clk); alarm_in = 8'h40;
    @(negedge clk); alarm_in = 8'h00;
    reg_access(1'b1, 8'h00, 8'h00, q);
    check("R10 sticky status", q, 8'h51);
    reg_access(1'b1, 8'h00, 8'h00, q);
    check("R10 cleared by read", q, 8'h00);

    // R11: sweep mask and alarm patterns
    for (int k = 0; k < 24; k++) begin
      logic [7:0] al, mk;
      al = 8'(k * 37 + 5); mk = 8'(k * 91 + 3);
      reg_access(1'b0, 8'h01, mk, q);
      check("R11 armed, empty status", irq, 0);
      @(negedge clk); alarm_in = al;
      @(negedge clk); alarm_in = 8'h00;
      check("R11 irq level", irq, int'((al & mk) != 0));
      reg_access(1'b1, 8'h00, 8'h00, q);
      check("R10 status value", q, al);
      check("R11 disarmed after read", irq, 0);
    end

    // R11: read disarms even with status pending
    reg_access(1'b0, 8'h01, 8'hFF, q);
    @(negedge clk); alarm_in = 8'h02;
    @(negedge clk); alarm_in = 8'h00;
    check("R11 irq on", irq, 1);
    reg_access(1'b1, 8'h00, 8'h00, q);
    @(negedge clk); alarm_in = 8'h04;
    @(negedge clk); alarm_in = 8'h00;
    check("R11 stays disarmed", irq, 0);
    reg_access(1'b0, 8'h01, 8'hFF, q);
    check("R11 re-armed by mask write", irq, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule